// File: doc/BRIEF.md
# Serial EEPROM Slave with Write-Protect Veto

This block is the two-wire serial slave front end of a small byte-addressed non-volatile store. The store itself is an on-chip register array. The block filters the SCL and SDA pins into the system clock domain and finds START and STOP conditions. It matches the 7-bit device address and builds the word address pointer. It takes one data byte per write transfer and returns bytes on reads. A read may address any location, continue from the current pointer, or run sequentially. After the STOP that ends a write, the write occupies a fixed number of system clocks. During that time the device address is not acknowledged, so a master can poll for completion.

A write-protect input guards the write. The guard window opens at the SCL rise that samples the last bit of the data byte and stays open until the timed write finishes. If the input is seen high before STOP, the write is dropped. If it is seen high while the write is running, the write stops at once, and the target location reads as the poison value 0xFF until it is written again. The open-drain SDA pin is modelled by an output enable that pulls the line low when set.

The word address is `ADDR_W` bits wide, from 9 to 11 bits. The low 8 bits come from the word-address byte. The upper `ADDR_W-8` bits come from the low device-address bits, and any device-address bits left over are compared with the select pins.

Top module: `eep_i2c_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) restarts framing at the device-address byte at any point, even in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle at any point.
- R2: The device byte is accepted only if bits [7:4] equal 4'b1010 and each select pin that is not used for addressing (with the default width, bit 3 against `sel_i[2]`) matches. A mismatched byte is not acknowledged, and SDA stays released until the next START or STOP.
- R3: The matching device byte, the word-address byte and the first data byte are each acknowledged by pulling SDA low in the ninth clock slot. A second data byte in the same transfer is not acknowledged.
- R4: The array is written only after STOP, and the write takes `TWR_CYC` system clocks. A START before STOP discards the pending byte. While the write runs, the device byte is not acknowledged.
- R5: A random read (a write header, a repeated START, then a read header) returns the byte at the given address. A read header alone returns the byte at the current pointer.
- R6: During a read the pointer advances after every byte and wraps from the top address to 0. A master ACK requests the next byte, and a master NACK ends the read.
- R7: Word address bits [ADDR_W-1:8] are taken from device byte bits [ADDR_W-8:1]. With the default width these are bits [2:1].
- R8: If write-protect is high at any time from the last-bit rise of the first data byte up to STOP, the write is dropped. The array keeps its old value, and the device is ready at once after STOP.
- R9: If write-protect goes high while the timed write runs, the write ends at once, the device becomes ready, and the location reads 0xFF until it is written again.
- R10: Write-protect levels before the last-bit rise of the first data byte have no effect on the write.
- R11: After reset SDA is released, every location reads 0x00, and the pointer is 0.
- R12: The slave changes its SDA drive only while SCL is low. Read data stays stable for the whole high phase of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired line) |
| sel_i | input | 3 | Device select pins |
| wp_i | input | 1 | Write-protect input, active high |
| sda_oe | output | 1 | When set, the slave pulls SDA low |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except on purpose for START and STOP, and no START lands while the slave is pulling SDA low. They also assume write-protect and the pins are slow compared with the two-flop filters. The bench master enforces these rules. It spaces every SDA change a quarter bit away from each SCL edge, starts conditions only from a released line, and keeps each write-protect pulse many clocks long. Polling runs back to back after STOP, so the count of refused polls bounds the length of the write interval.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_WAIT
  } eep_state_t;

  localparam logic [3:0] DEV_PREFIX  = 4'b1010;
  localparam logic [7:0] POISON_BYTE = 8'hFF;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic rst_s_n,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] rst_q;
  logic [1:0] scl_q, sda_q, wp_q;
  logic       scl_d, sda_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      wp_q  <= 2'b00;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      wp_q  <= {wp_q[0], wp_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign wp_s      = wp_q[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int TWR_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(TWR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TWR_CYC - 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign done_o = busy_q & ~abort_i & (cnt_q == LAST);
  assign busy_o = busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (abort_i || done_o) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(TWR_CYC))); // R4
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && abort_i && !start_i) |=> !busy_q); // R9
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              poison_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]       mem_q   [DEPTH];
  logic [DEPTH-1:0] undef_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      undef_q <= '0;
    end else if (we_i) begin
      undef_q[wr_addr_i] <= 1'b0;
    end else if (poison_i) begin
      undef_q[wr_addr_i] <= 1'b1;
    end
  end

  assign rd_data_o = undef_q[rd_addr_i] ? POISON_BYTE : mem_q[rd_addr_i];

  AST_POISON_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (poison_i && !we_i) |=> undef_q[$past(wr_addr_i)]); // R9
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int TWR_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [2:0] PIN_MASK = 3'(7 << HI_W);

  logic rst_s_n, scl_s, sda_s, wp_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy, done, tm_start, abort_hit;
  logic [7:0] rd_data, rx_byte;
  logic dev_match;

  eep_state_t        st_q, st_n, nxt_q, nxt_n;
  logic [3:0]        bitcnt_q, bitcnt_n;
  logic [7:0]        shreg_q, shreg_n, wdata_q, wdata_n;
  logic              oe_q, oe_n, in_ack_q, in_ack_n, ack_q, ack_n;
  logic              mack_q, mack_n, have_q, have_n, cancel_q, cancel_n;
  logic [ADDR_W-1:0] waddr_q, waddr_n, wr_addr_q, wr_addr_n;

  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .rst_s_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s), .wp_s(wp_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_wr_timer #(.TWR_CYC(TWR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .start_i(tm_start), .abort_i(abort_hit),
    .busy_o(busy), .done_o(done)
  );

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_s_n), .we_i(done), .poison_i(abort_hit),
    .wr_addr_i(wr_addr_q), .wr_data_i(wdata_q),
    .rd_addr_i(waddr_q), .rd_data_o(rd_data)
  );

  assign abort_hit = busy & wp_s;
  assign rx_byte   = {shreg_q[6:0], sda_s};
  assign dev_match = (rx_byte[7:4] == DEV_PREFIX)
                   && (((rx_byte[3:1] ^ sel_i) & PIN_MASK) == 3'b000)
                   && !busy;

  always_comb begin
    st_n      = st_q;
    nxt_n     = nxt_q;
    bitcnt_n  = bitcnt_q;
    shreg_n   = shreg_q;
    wdata_n   = wdata_q;
    oe_n      = oe_q;
    in_ack_n  = in_ack_q;
    ack_n     = ack_q;
    mack_n    = mack_q;
    have_n    = have_q;
    cancel_n  = cancel_q;
    waddr_n   = waddr_q;
    wr_addr_n = wr_addr_q;
    tm_start  = 1'b0;
    if (start_det) begin
      st_n     = ST_DEV;
      bitcnt_n = '0;
      in_ack_n = 1'b0;
      oe_n     = 1'b0;
      have_n   = 1'b0;
      cancel_n = 1'b0;
    end else if (stop_det) begin
      tm_start = have_q && !cancel_q && !wp_s;
      have_n   = 1'b0;
      cancel_n = 1'b0;
      st_n     = ST_IDLE;
      oe_n     = 1'b0;
      in_ack_n = 1'b0;
      bitcnt_n = '0;
    end else begin
      if (have_q && wp_s) cancel_n = 1'b1;
      unique case (st_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && !in_ack_q) begin
            shreg_n  = rx_byte;
            bitcnt_n = bitcnt_q + 4'd1;
            if (bitcnt_q == 4'd7) begin
              unique case (st_q)
                ST_DEV: begin
                  if (dev_match) begin
                    ack_n = 1'b1;
                    waddr_n[ADDR_W-1:8] = rx_byte[HI_W:1];
                    nxt_n = rx_byte[0] ? ST_RDAT : ST_WADR;
                  end else begin
                    ack_n = 1'b0;
                    nxt_n = ST_WAIT;
                  end
                end
                ST_WADR: begin
                  ack_n = 1'b1;
                  waddr_n[7:0] = rx_byte;
                  nxt_n = ST_WDAT;
                end
                default: begin
                  if (!have_q) begin
                    ack_n     = 1'b1;
                    wdata_n   = rx_byte;
                    wr_addr_n = waddr_q;
                    have_n    = 1'b1;
                    cancel_n  = wp_s;
                    nxt_n     = ST_WDAT;
                  end else begin
                    ack_n = 1'b0;
                    nxt_n = ST_WAIT;
                  end
                end
              endcase
            end
          end else if (scl_fall && !in_ack_q && bitcnt_q == 4'd8) begin
            in_ack_n = 1'b1;
            oe_n     = ack_q;
          end else if (scl_fall && in_ack_q) begin
            in_ack_n = 1'b0;
            bitcnt_n = '0;
            oe_n     = 1'b0;
            st_n     = nxt_q;
            if (nxt_q == ST_RDAT) begin
              shreg_n = rd_data;
              oe_n    = ~rd_data[7];
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise && !in_ack_q) begin
            bitcnt_n = bitcnt_q + 4'd1;
            if (bitcnt_q == 4'd7) waddr_n = waddr_q + 1'b1;
          end else if (scl_fall && !in_ack_q) begin
            if (bitcnt_q == 4'd8) begin
              oe_n     = 1'b0;
              in_ack_n = 1'b1;
            end else begin
              shreg_n = {shreg_q[6:0], 1'b0};
              oe_n    = ~shreg_q[6];
            end
          end else if (scl_rise && in_ack_q) begin
            mack_n = ~sda_s;
          end else if (scl_fall && in_ack_q) begin
            in_ack_n = 1'b0;
            bitcnt_n = '0;
            if (mack_q) begin
              shreg_n = rd_data;
              oe_n    = ~rd_data[7];
            end else begin
              st_n = ST_WAIT;
              oe_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      wdata_q   <= '0;
      oe_q      <= 1'b0;
      in_ack_q  <= 1'b0;
      ack_q     <= 1'b0;
      mack_q    <= 1'b0;
      have_q    <= 1'b0;
      cancel_q  <= 1'b0;
      waddr_q   <= '0;
      wr_addr_q <= '0;
    end else begin
      st_q      <= st_n;
      nxt_q     <= nxt_n;
      bitcnt_q  <= bitcnt_n;
      shreg_q   <= shreg_n;
      wdata_q   <= wdata_n;
      oe_q      <= oe_n;
      in_ack_q  <= in_ack_n;
      ack_q     <= ack_n;
      mack_q    <= mack_n;
      have_q    <= have_n;
      cancel_q  <= cancel_n;
      waddr_q   <= waddr_n;
      wr_addr_q <= wr_addr_n;
    end
  end

  assign sda_oe = oe_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(oe_q) |-> !scl_s); // R12
  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_WAIT) |-> !oe_q); // R2
  AST_BUSY_NO_DEV_ACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_DEV && in_ack_q && busy) |-> !oe_q); // R4
  AST_CANCEL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stop_det && cancel_q) |=> !busy); // R8
endmodule

// File: tb/sim_eep_i2c_slave.sv
`timescale 1ns/1ps
module sim_eep_i2c_slave;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] sel = 3'b100;
  logic       sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  eep_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sel_i(sel), .wp_i(wp), .sda_oe(sda_oe)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic [9:0] a, input bit rd);
    return {4'hA, 1'b1, a[9:8], rd};
  endfunction

  task automatic i2c_start;
    sda_m = 1'b1; wait_cyc(Q);
    scl = 1'b1;   wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl = 1'b0;
  endtask

  task automatic i2c_stop;
    wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl = 1'b1;   wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic send_bit(input bit b);
    wait_cyc(Q); sda_m = b;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(2*Q); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_cyc(Q); sda_m = 1'b1;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(Q); ack = ~sda_line;
    wait_cyc(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d, output bit stable);
    logic s0, s1;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(Q); sda_m = 1'b1;
      wait_cyc(Q); scl = 1'b1;
      wait_cyc(1); s0 = sda_line;
      wait_cyc(2*Q - 2); s1 = sda_line;
      wait_cyc(1); scl = 1'b0;
      d[i] = s0;
      if (s0 !== s1) stable = 1'b0;
    end
    wait_cyc(Q); sda_m = ~mack;
    wait_cyc(Q); scl = 1'b1;
    wait_cyc(2*Q); scl = 1'b0;
    wait_cyc(Q); sda_m = 1'b1;
  endtask

  task automatic poll_ready(output int nacks);
    bit a;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      i2c_start; send_byte(dev(10'h0, 1'b0), a); i2c_stop;
      if (a) break;
      nacks++;
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d, output bit k1, output bit k2, output bit k3);
    i2c_start;
    send_byte(dev(a, 1'b0), k1);
    send_byte(a[7:0], k2);
    send_byte(d, k3);
    i2c_stop;
  endtask

  task automatic rand_read(input logic [9:0] a, input int n, output logic [23:0] q, output bit stab);
    bit k;
    logic [7:0] d;
    bit s;
    stab = 1'b1;
    q = '0;
    i2c_start;
    send_byte(dev(a, 1'b0), k);
    send_byte(a[7:0], k);
    i2c_start;
    send_byte(dev(a, 1'b1), k);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d, s);
      q[8*i +: 8] = d;
      if (!s) stab = 1'b0;
    end
    i2c_stop;
  endtask

  task automatic write_poll(input logic [9:0] a, input logic [7:0] d);
    bit k1, k2, k3;
    int n;
    do_write(a, d, k1, k2, k3);
    poll_ready(n);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bit k, s;
    check("R11 sda released after reset", sda_oe, 0);
    i2c_start;
    send_byte(dev(10'h0, 1'b1), k);
    recv_byte(1'b0, d, s);
    i2c_stop;
    check("R11 current read ack at reset", k, 1);
    check("R11 location 0 reads zero", d, 8'h00);
  endtask

  task automatic t_addr_match;
    bit k;
    i2c_start; send_byte(8'hB0, k);
    check("R2 wrong prefix nacked", k, 0);
    send_byte(8'h00, k);
    check("R2 following byte ignored", k, 0);
    i2c_stop;
    i2c_start; send_byte(8'hA0, k);
    check("R2 select pin mismatch nacked", k, 0);
    i2c_stop;
    i2c_start; send_byte(8'hA8, k);
    check("R2 matching address acked", k, 1);
    i2c_stop;
  endtask

  task automatic t_write_timing;
    bit k1, k2, k3;
    int n;
    logic [23:0] q;
    bit st;
    i2c_start;
    send_byte(dev(10'h155, 1'b0), k1);
    send_byte(8'h55, k2);
    send_byte(8'h99, k3);
    i2c_start;
    send_byte(dev(10'h0, 1'b0), k1);
    check("R4 no write before stop", k1, 1);
    i2c_stop;
    rand_read(10'h155, 1, q, st);
    check("R4 start discards pending byte", q[7:0], 8'h00);
    do_write(10'h2A5, 8'h3C, k1, k2, k3);
    check("R3 device byte acked", k1, 1);
    check("R3 word address acked", k2, 1);
    check("R3 data byte acked", k3, 1);
    poll_ready(n);
    check("R4 busy polls within write time", (n >= 3 && n <= 6), 1);
    rand_read(10'h2A5, 1, q, st);
    check("R5 random read data", q[7:0], 8'h3C);
    check("R12 read data stable while scl high", st, 1);
    rand_read(10'h0A5, 1, q, st);
    check("R7 upper bits select other location", q[7:0], 8'h00);
  endtask

  task automatic t_second_byte;
    bit k;
    logic [23:0] q;
    bit st;
    int n;
    i2c_start;
    send_byte(dev(10'h040, 1'b0), k);
    send_byte(8'h40, k);
    send_byte(8'h61, k);
    send_byte(8'h62, k);
    check("R3 second data byte nacked", k, 0);
    i2c_stop;
    poll_ready(n);
    rand_read(10'h040, 2, q, st);
    check("R3 first data byte written", q[7:0], 8'h61);
    check("R3 second data byte dropped", q[15:8], 8'h00);
  endtask

  task automatic t_current_read;
    logic [23:0] q;
    logic [7:0] d;
    bit st, k, s;
    write_poll(10'h010, 8'h77);
    write_poll(10'h011, 8'h88);
    rand_read(10'h010, 1, q, st);
    check("R5 random read first", q[7:0], 8'h77);
    i2c_start;
    send_byte(dev(10'h011, 1'b1), k);
    recv_byte(1'b0, d, s);
    i2c_stop;
    check("R5 current address read", d, 8'h88);
  endtask

  task automatic t_wrap;
    logic [23:0] q;
    bit st;
    write_poll(10'h3FF, 8'h11);
    write_poll(10'h000, 8'h22);
    rand_read(10'h3FF, 3, q, st);
    check("R6 top location", q[7:0], 8'h11);
    check("R6 wrap to zero", q[15:8], 8'h22);
    check("R6 increment past zero", q[23:16], 8'h00);
  endtask

  task automatic t_resync;
    bit k;
    i2c_start;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_start;
    send_byte(dev(10'h0, 1'b0), k);
    check("R1 start mid byte reframes", k, 1);
    i2c_stop;
    i2c_start;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    i2c_stop;
    i2c_start;
    send_byte(dev(10'h0, 1'b0), k);
    check("R1 stop mid byte then new transfer", k, 1);
    i2c_stop;
  endtask

  task automatic t_wp_cancel;
    bit k;
    int n;
    logic [23:0] q;
    bit st;
    write_poll(10'h120, 8'h44);
    i2c_start;
    send_byte(dev(10'h120, 1'b0), k);
    send_byte(8'h20, k);
    send_byte(8'hEE, k);
    wp = 1'b1;
    wait_cyc(Q);
    wp = 1'b0;
    i2c_stop;
    poll_ready(n);
    check("R8 no busy after cancelled write", n, 0);
    rand_read(10'h120, 1, q, st);
    check("R8 old data kept", q[7:0], 8'h44);
  endtask

  task automatic t_wp_early;
    bit k;
    int n;
    logic [23:0] q;
    bit st;
    i2c_start;
    send_byte(dev(10'h121, 1'b0), k);
    wp = 1'b1;
    send_byte(8'h21, k);
    wp = 1'b0;
    send_byte(8'hC3, k);
    i2c_stop;
    poll_ready(n);
    rand_read(10'h121, 1, q, st);
    check("R10 early protect level ignored", q[7:0], 8'hC3);
  endtask

  task automatic t_wp_abort;
    bit k1, k2, k3;
    int n;
    logic [23:0] q;
    bit st;
    do_write(10'h301, 8'h5A, k1, k2, k3);
    wait_cyc(100);
    wp = 1'b1;
    wait_cyc(20);
    wp = 1'b0;
    wait_cyc(10);
    poll_ready(n);
    check("R9 ready right after abort", n, 0);
    rand_read(10'h301, 1, q, st);
    check("R9 aborted location poisoned", q[7:0], 8'hFF);
    write_poll(10'h301, 8'h5A);
    rand_read(10'h301, 1, q, st);
    check("R9 rewrite restores", q[7:0], 8'h5A);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset;
    t_addr_match;
    t_write_timing;
    t_second_byte;
    t_current_read;
    t_wrap;
    t_resync;
    t_wp_cancel;
    t_wp_early;
    t_wp_abort;
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule